// File: doc/BRIEF.md
# Stack and Instruction-Stream Byte Sequencer

This block owns a processor's stack pointer and program counter. It turns each stack or instruction-stream request into a sequence of single-byte accesses on a byte-wide memory port. A host issues one request: an operation code plus up to sixteen bits of data. The block runs one or two byte accesses, one per cycle, then pulses `done`. For reads it also presents the assembled result on `rsp_data`.

The stack grows downward, and the stack pointer marks the next free byte. Sixteen-bit values are stored big-endian, so the high byte sits at the lower address. Two extra operations load the stack pointer or the program counter straight from the request data, with no memory access. If memory flags an access as out of range, the sequence stops: `err` pulses instead of `done`, and neither pointer moves.

Top module: `stack_seq`

## Requirements
- R1: After reset, `sp` equals parameter SP_INIT and `pc` equals PC_INIT, and `busy`, `done`, `err`, `mem_we` and `mem_re` are all 0.
- R2: Op code 0 (byte push) writes `req_data[7:0]` at address SP in the cycle after the request is accepted. On the next edge `done` pulses, SP becomes SP-1 and `rsp_data` becomes 0.
- R3: Op code 1 (word push) runs two write cycles. The first writes `req_data[15:8]` at SP-1 and the second writes `req_data[7:0]` at SP. `done` then pulses and SP becomes SP-2.
- R4: Op code 2 (byte pop) reads address SP+1 in one cycle. `done` then pulses with `rsp_data` = {8'h00, byte}, and SP becomes SP+1.
- R5: Op code 3 (word pop) reads the high byte at SP+1, then the low byte at SP+2. `done` then pulses with `rsp_data` = {high, low}, and SP becomes SP+2.
- R6: Op code 4 (byte fetch) reads at PC and advances PC by 1. Op code 5 (word fetch) reads the high byte at PC and the low byte at PC+1, then advances PC by 2. The result is placed on `rsp_data` as in R4 and R5.
- R7: Op code 6 loads SP from `req_data`, and op code 7 loads PC from `req_data`. Either one pulses `done` on the edge after acceptance, with no memory access.
- R8: All address and pointer arithmetic wraps modulo 2^16.
- R9: If `mem_fault` is high during any access cycle, the sequence ends on that edge. `err` pulses for one cycle, `done` does not pulse, and SP, PC and `rsp_data` keep their values.
- R10: A request presented while `busy` is high is ignored. It causes no pointer change and no extra `done`.
- R11: At most one of `mem_we` and `mem_re` is high in a cycle, and either one is high only while `busy` is high. `done` and `err` are never high together, and SP and PC change only on an edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 3 | Operation code (0..7, see requirements) |
| req_data | input | 16 | Push data or pointer load value |
| busy | output | 1 | A byte sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle abort pulse after a memory fault |
| rsp_data | output | 16 | Assembled read result, updated on done |
| sp | output | 16 | Stack pointer |
| pc | output | 16 | Program counter |
| mem_addr | output | 16 | Byte address |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid in the same cycle |
| mem_fault | input | 1 | Out-of-range flag for the current access |

## Verification
Several properties are checked on every cycle: one access at a time, accesses only while busy, `done` and `err` never together, pointers that move only with `done`, and pointers that hold across an abort. The bench scenarios show what those checks cannot. These are the exact addresses and byte order of each access, the values the pointers land on, and the assembled read data. They also cover wrap-around at 0xFFFF/0x0000, a fault on the second byte, and a request dropped while busy.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

    parameter int STK_AW = 16;
    parameter int STK_BW = 8;

    typedef enum logic [2:0] {
        OP_PUSH_B  = 3'd0,
        OP_PUSH_W  = 3'd1,
        OP_POP_B   = 3'd2,
        OP_POP_W   = 3'd3,
        OP_FETCH_B = 3'd4,
        OP_FETCH_W = 3'd5,
        OP_LOAD_SP = 3'd6,
        OP_LOAD_PC = 3'd7
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BYTE0 = 2'd1,
        ST_BYTE1 = 2'd2
    } stk_state_e;

    typedef struct packed {
        logic [STK_AW-1:0] addr;
        logic              we;
        logic              re;
        logic [STK_BW-1:0] wdata;
    } stk_access_t;

    function automatic logic op_is_wide(stk_op_e op);
        return (op == OP_PUSH_W) || (op == OP_POP_W) || (op == OP_FETCH_W);
    endfunction

    function automatic logic op_is_load(stk_op_e op);
        return (op == OP_LOAD_SP) || (op == OP_LOAD_PC);
    endfunction

    function automatic logic op_is_read(stk_op_e op);
        return (op == OP_POP_B) || (op == OP_POP_W) ||
               (op == OP_FETCH_B) || (op == OP_FETCH_W);
    endfunction

endpackage

// File: rtl/stack_seq_addr.sv
module stack_seq_addr
    import stack_seq_pkg::*;
#(
    parameter int AW = STK_AW
) (
    input  stk_state_e        state,
    input  stk_op_e           op,
    input  logic [2*STK_BW-1:0] data,
    input  logic [AW-1:0]     sp,
    input  logic [AW-1:0]     pc,
    output stk_access_t       acc
);
    logic          second;
    logic [AW-1:0] step;

    always_comb begin
        second = (state == ST_BYTE1);
        step   = {{(AW-1){1'b0}}, second};
        acc    = '0;
        if (state != ST_IDLE) begin
            unique case (op)
                OP_PUSH_B: begin
                    acc.addr  = sp;
                    acc.we    = 1'b1;
                    acc.wdata = data[STK_BW-1:0];
                end
                OP_PUSH_W: begin
                    acc.addr  = sp - {{(AW-1){1'b0}}, 1'b1} + step;
                    acc.we    = 1'b1;
                    acc.wdata = second ? data[STK_BW-1:0] : data[2*STK_BW-1:STK_BW];
                end
                OP_POP_B: begin
                    acc.addr = sp + {{(AW-1){1'b0}}, 1'b1};
                    acc.re   = 1'b1;
                end
                OP_POP_W: begin
                    acc.addr = sp + {{(AW-1){1'b0}}, 1'b1} + step;
                    acc.re   = 1'b1;
                end
                OP_FETCH_B: begin
                    acc.addr = pc;
                    acc.re   = 1'b1;
                end
                OP_FETCH_W: begin
                    acc.addr = pc + step;
                    acc.re   = 1'b1;
                end
                default: acc = '0;
            endcase
        end
    end
endmodule

// File: rtl/stack_seq_ptrs.sv
module stack_seq_ptrs
    import stack_seq_pkg::*;
#(
    parameter int            AW      = STK_AW,
    parameter logic [AW-1:0] SP_INIT = '0,
    parameter logic [AW-1:0] PC_INIT = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit,
    input  stk_op_e       op,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] pc
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [AW-1:0] TWO = ONE << 1;

    logic [AW-1:0] sp_n, pc_n;

    always_comb begin
        sp_n = sp;
        pc_n = pc;
        unique case (op)
            OP_PUSH_B:  sp_n = sp - ONE;
            OP_PUSH_W:  sp_n = sp - TWO;
            OP_POP_B:   sp_n = sp + ONE;
            OP_POP_W:   sp_n = sp + TWO;
            OP_FETCH_B: pc_n = pc + ONE;
            OP_FETCH_W: pc_n = pc + TWO;
            OP_LOAD_SP: sp_n = load_val;
            OP_LOAD_PC: pc_n = load_val;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= SP_INIT;
            pc <= PC_INIT;
        end else if (commit) begin
            sp <= sp_n;
            pc <= pc_n;
        end
    end
endmodule

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
    import stack_seq_pkg::*;
#(
    parameter int DW = 2*STK_BW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  stk_op_e           req_op,
    input  logic [DW-1:0]     req_data,
    input  logic [STK_BW-1:0] mem_rdata,
    input  logic              mem_fault,
    output stk_state_e        state,
    output stk_op_e           op_q,
    output logic [DW-1:0]     data_q,
    output logic              commit,
    output stk_op_e           commit_op,
    output logic [DW-1:0]     commit_data,
    output logic              done,
    output logic              err,
    output logic [DW-1:0]     rsp_data
);
    stk_state_e        state_n;
    logic [STK_BW-1:0] hi_q;
    logic              accept, active, finish, abort;
    logic [DW-1:0]     rd_word;

    always_comb begin
        accept = req_valid && (state == ST_IDLE);
        active = (state != ST_IDLE);
        abort  = active && mem_fault;
        finish = active && !mem_fault &&
                 ((state == ST_BYTE1) || !op_is_wide(op_q));

        state_n = state;
        unique case (state)
            ST_IDLE:  if (accept && !op_is_load(req_op)) state_n = ST_BYTE0;
            ST_BYTE0: state_n = (mem_fault || !op_is_wide(op_q)) ? ST_IDLE : ST_BYTE1;
            ST_BYTE1: state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase

        commit      = (accept && op_is_load(req_op)) || finish;
        commit_op   = active ? op_q : req_op;
        commit_data = active ? data_q : req_data;

        if (op_is_wide(op_q)) rd_word = {hi_q, mem_rdata};
        else                  rd_word = {{(DW-STK_BW){1'b0}}, mem_rdata};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            op_q     <= OP_PUSH_B;
            data_q   <= '0;
            hi_q     <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            rsp_data <= '0;
        end else begin
            state <= state_n;
            done  <= commit;
            err   <= abort;
            if (accept) begin
                op_q   <= req_op;
                data_q <= req_data;
            end
            if (state == ST_BYTE0 && !mem_fault) hi_q <= mem_rdata;
            if (commit) rsp_data <= (active && op_is_read(op_q)) ? rd_word : '0;
        end
    end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stack_seq_pkg::*;
#(
    parameter int                AW      = STK_AW,
    parameter logic [AW-1:0]     SP_INIT = 16'h00F0,
    parameter logic [AW-1:0]     PC_INIT = 16'h0010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [15:0]       req_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [15:0]       rsp_data,
    output logic [AW-1:0]     sp,
    output logic [AW-1:0]     pc,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [STK_BW-1:0] mem_wdata,
    input  logic [STK_BW-1:0] mem_rdata,
    input  logic              mem_fault
);
    stk_state_e  state;
    stk_op_e     op_q, commit_op;
    logic [15:0] data_q, commit_data;
    logic        commit;
    stk_access_t acc;

    stack_seq_ctrl #(.DW(16)) u_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_op(stk_op_e'(req_op)), .req_data(req_data),
        .mem_rdata(mem_rdata), .mem_fault(mem_fault),
        .state(state), .op_q(op_q), .data_q(data_q),
        .commit(commit), .commit_op(commit_op), .commit_data(commit_data),
        .done(done), .err(err), .rsp_data(rsp_data)
    );

    stack_seq_addr #(.AW(AW)) u_addr (
        .state(state), .op(op_q), .data(data_q), .sp(sp), .pc(pc), .acc(acc)
    );

    stack_seq_ptrs #(.AW(AW), .SP_INIT(SP_INIT), .PC_INIT(PC_INIT)) u_ptrs (
        .clk(clk), .rst(rst), .commit(commit), .op(commit_op),
        .load_val(commit_data[AW-1:0]), .sp(sp), .pc(pc)
    );

    assign busy      = (state != ST_IDLE);
    assign mem_addr  = acc.addr;
    assign mem_we    = acc.we;
    assign mem_re    = acc.re;
    assign mem_wdata = acc.wdata;
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] sp,
    input logic [AW-1:0] pc
);
    a_r11_one_access: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    a_r11_access_when_busy: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> busy);

    a_r11_done_err_apart: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    a_r11_sp_moves_with_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(sp) |-> done);

    a_r11_pc_moves_with_done: assert property (@(posedge clk) disable iff (rst)
        !$stable(pc) |-> done);

    a_r9_abort_keeps_ptrs: assert property (@(posedge clk) disable iff (rst)
        err |-> ($stable(sp) && $stable(pc)));
endmodule

bind stack_seq stack_seq_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err),
    .mem_we(mem_we), .mem_re(mem_re), .sp(sp), .pc(pc)
);

// File: tb/stack_seq_tb.sv
module stack_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [15:0] req_data = 16'h0;
    logic        busy, done, err, mem_we, mem_re;
    logic [15:0] rsp_data, sp, pc, mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_fault;
    logic        fault_en = 1'b0;
    logic [15:0] fault_addr = 16'h0;
    logic [7:0]  tbmem [256];

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    stack_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .busy(busy), .done(done), .err(err),
        .rsp_data(rsp_data), .sp(sp), .pc(pc), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_fault(mem_fault)
    );

    assign mem_rdata = tbmem[mem_addr[7:0]];
    assign mem_fault = fault_en && (mem_addr == fault_addr) && (mem_we || mem_re);

    always @(posedge clk) if (mem_we && !mem_fault) tbmem[mem_addr[7:0]] <= mem_wdata;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] data;
        logic [15:0] rsp;
        logic [15:0] sp;
        logic [15:0] pc;
        logic [15:0] a0;
        logic [3:0]  cyc;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 16'h00A5, 16'h0000, 16'h00EF, 16'h0010, 16'h00F0, 4'd2},
        '{3'd1, 16'h1234, 16'h0000, 16'h00ED, 16'h0010, 16'h00EE, 4'd3},
        '{3'd3, 16'h0000, 16'h1234, 16'h00EF, 16'h0010, 16'h00EE, 4'd3},
        '{3'd2, 16'h0000, 16'h00A5, 16'h00F0, 16'h0010, 16'h00F0, 4'd2},
        '{3'd7, 16'h0020, 16'h0000, 16'h00F0, 16'h0020, 16'h0000, 4'd1},
        '{3'd4, 16'h0000, 16'h00C3, 16'h00F0, 16'h0021, 16'h0020, 4'd2},
        '{3'd5, 16'h0000, 16'h5A7E, 16'h00F0, 16'h0023, 16'h0021, 4'd3},
        '{3'd6, 16'h0001, 16'h0000, 16'h0001, 16'h0023, 16'h0000, 4'd1},
        '{3'd1, 16'hBEEF, 16'h0000, 16'hFFFF, 16'h0023, 16'h0000, 4'd3},
        '{3'd0, 16'h0077, 16'h0000, 16'hFFFE, 16'h0023, 16'hFFFF, 4'd2},
        '{3'd2, 16'h0000, 16'h0077, 16'hFFFF, 16'h0023, 16'hFFFF, 4'd2},
        '{3'd3, 16'h0000, 16'hBEEF, 16'h0001, 16'h0023, 16'h0000, 4'd3},
        '{3'd7, 16'hFFFF, 16'h0000, 16'h0001, 16'hFFFF, 16'h0000, 4'd1},
        '{3'd5, 16'h0000, 16'h77BE, 16'h0001, 16'h0001, 16'hFFFF, 4'd3}
    };

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4, 3'd5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [15:0] d,
                          output int ncyc, output logic [15:0] a0, output logic saw_err);
        logic first;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        ncyc = 1; a0 = 16'h0; first = 1'b1;
        while (!(done || err) && ncyc < 20) begin
            if ((mem_re || mem_we) && first) begin a0 = mem_addr; first = 1'b0; end
            @(negedge clk);
            ncyc++;
        end
        saw_err = err;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int          ncyc;
        logic [15:0] a0;
        logic        se;
        for (int i = 0; i < 256; i++) tbmem[i] = 8'h00;
        tbmem[8'h20] = 8'hC3; tbmem[8'h21] = 8'h5A; tbmem[8'h22] = 8'h7E;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 sp", sp, 16'h00F0);
        check("R1 pc", pc, 16'h0010);
        check("R1 flags", {11'h0, busy, done, err, mem_we, mem_re}, 16'h0);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i].op, VEC[i].data, ncyc, a0, se);
            check({op_tag(VEC[i].op), " cycles"}, 16'(ncyc), {12'h0, VEC[i].cyc});
            check({op_tag(VEC[i].op), " done"}, {15'h0, done}, 16'h1);
            check({op_tag(VEC[i].op), " rsp"}, rsp_data, VEC[i].rsp);
            check({op_tag(VEC[i].op), " R8 sp"}, sp, VEC[i].sp);
            check({op_tag(VEC[i].op), " R8 pc"}, pc, VEC[i].pc);
            if (VEC[i].cyc > 4'd1) check({op_tag(VEC[i].op), " first addr"}, a0, VEC[i].a0);
            // R11 no access in the done cycle
            check("R11 idle at done", {14'h0, mem_we, mem_re}, 16'h0);
        end
        // R3 big-endian placement across the wrap
        check("R3 high byte low addr", {8'h0, tbmem[8'h00]}, 16'h00BE);
        check("R3 low byte high addr", {8'h0, tbmem[8'h01]}, 16'h00EF);

        // R9 fault on second byte of a word pop
        fault_en = 1'b1; fault_addr = 16'h0003;
        run_op(3'd3, 16'h0, ncyc, a0, se);
        check("R9 err pulse", {15'h0, se}, 16'h1);
        check("R9 no done", {15'h0, done}, 16'h0);
        check("R9 cycles", 16'(ncyc), 16'd3);
        check("R9 sp kept", sp, 16'h0001);
        check("R9 rsp kept", rsp_data, 16'h77BE);
        @(negedge clk);
        check("R9 err one cycle", {14'h0, err, busy}, 16'h0);
        // R9 fault on a byte push
        fault_addr = 16'h0001;
        run_op(3'd0, 16'h0099, ncyc, a0, se);
        check("R9 push err", {15'h0, se}, 16'h1);
        check("R9 push sp kept", sp, 16'h0001);
        fault_en = 1'b0;

        // R10 request while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd1; req_data = 16'h4455;
        @(negedge clk);
        check("R10 busy", {15'h0, busy}, 16'h1);
        req_op = 3'd6; req_data = 16'h1234;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 done", {15'h0, done}, 16'h1);
        check("R10 sp", sp, 16'hFFFF);
        @(negedge clk);
        check("R10 no extra done", {14'h0, done, busy}, 16'h0);
        check("R10 sp after", sp, 16'hFFFF);
        check("R3 push hi", {tbmem[8'h00], tbmem[8'h01]}, 16'h4455);

        finish_run();
    end
endmodule